// File: doc/BRIEF.md
# Product-Term Macrocell

This block is one programmable cell of a small programmable logic fabric. A bank of fan-in signals feeds five AND terms. Each term is shaped by two configuration masks, one picking true literals and one picking complemented literals. A per-term steering code then sends each term to one of two places. It can go to the cell's sum-of-products logic value, or it can drive one of four controls of the cell's single storage bit: register clock, asynchronous clear, asynchronous preset or output driver enable. A control with no term steered to it falls back to a global input. The global inputs never enter term formation.

The logic value, optionally inverted, either reaches the output directly or is held in a D register. All configuration arrives on static parallel ports. The cell runs inside a system clock domain. A term-driven or global register clock is treated as a sampled signal: the register loads on the system clock edge that sees this signal rise. Clear and preset act on the output at once, without waiting for any edge.

Top module: `pt_macrocell`

## Requirements
- R1: Term i uses mask bits [i*FANIN_W +: FANIN_W]. It is 1 when every fan-in bit whose true-mask bit is set is 1 and every fan-in bit whose complement-mask bit is set is 0. A term with no bit set in either mask is 0.
- R2: Term i is routed by the 3-bit field cfg_steer_i[3i +: 3]. The codes are: 0 logic value, 1 register clock, 2 asynchronous clear, 3 asynchronous preset, 4 output enable. Codes 5 to 7 leave the term unconnected.
- R3: The logic value is the OR of all terms coded 0, XOR cfg_invert_i.
- R4: With cfg_bypass_i = 1, dout_o equals the logic value combinationally.
- R5: With cfg_bypass_i = 0, the register loads the logic value at a clk edge only when the selected register clock is 1 at that edge and was 0 at the previous edge. At all other edges it holds. The selected clock is the OR of terms coded 1, or gclk_i when no term is coded 1.
- R6: The selected clear is the OR of terms coded 2, or grst_i when no term is coded 2. While it is 1, dout_o with cfg_bypass_i = 0 is 0 in the same cycle, and the register is cleared at the next edge.
- R7: The selected preset is the OR of terms coded 3, or 0 when none is coded 3. It forces dout_o to 1 and sets the register. Clear takes priority over preset.
- R8: oe_o is the OR of terms coded 4. When no term is coded 4, oe_o follows goe_i, and goe_i has no effect whenever some term is coded 4.
- R9: rst = 1 at a clk edge clears the register, so dout_o with cfg_bypass_i = 0 reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the register and edge detector |
| fanin_i | input | FANIN_W | Fan-in signal bank |
| cfg_true_i | input | NUM_PT*FANIN_W | True-literal masks, one slice per term |
| cfg_comp_i | input | NUM_PT*FANIN_W | Complement-literal masks, one slice per term |
| cfg_steer_i | input | NUM_PT*3 | Steering code per term |
| cfg_bypass_i | input | 1 | 1 selects the combinational output path |
| cfg_invert_i | input | 1 | Inverts the logic value |
| gclk_i | input | 1 | Global register clock fallback |
| grst_i | input | 1 | Global clear fallback |
| goe_i | input | 1 | Global output enable fallback |
| dout_o | output | 1 | Cell output value |
| oe_o | output | 1 | Output driver enable; the pad floats while low |

## Verification
A wrong term or steering decode shows at dout_o or oe_o in the same cycle as the fan-in change, because the whole path from fan-in to these outputs is combinational when bypassed. A stale edge-detector state or a missed clear shows one clock edge later, as a captured value that differs from the computed logic value. A wrongly ordered clear and preset shows immediately as a 1 where a 0 belongs. The sweeps cover every mask and input combination of one term and every steering subset of five fixed terms. Any decode fault therefore reaches an output within a few nanoseconds of its stimulus.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int STEER_W = 3;

    typedef enum logic [STEER_W-1:0] {
        STEER_SUM  = 3'd0,
        STEER_CLK  = 3'd1,
        STEER_ARST = 3'd2,
        STEER_ASET = 3'd3,
        STEER_OE   = 3'd4
    } steer_e;

    // Resolved control set for the storage bit and driver
    typedef struct packed {
        logic sclk;
        logic arst;
        logic aset;
        logic oe;
    } ctl_s;

    // AND of selected literals; empty literal set yields 0
    function automatic logic lit_and(input logic used, input logic all_ok);
        return used & all_ok;
    endfunction

endpackage

// File: rtl/mc_pterm_array.sv
module mc_pterm_array
    import mc_pkg::*;
#(
    parameter int NUM_PT  = 5,
    parameter int FANIN_W = 40
) (
    input  logic [FANIN_W-1:0]        fanin_i,
    input  logic [NUM_PT*FANIN_W-1:0] true_i,
    input  logic [NUM_PT*FANIN_W-1:0] comp_i,
    output logic [NUM_PT-1:0]         pt_o
);

    for (genvar g = 0; g < NUM_PT; g++) begin : g_term
        logic [FANIN_W-1:0] tm, cm, ok;
        assign tm = true_i[g*FANIN_W +: FANIN_W];
        assign cm = comp_i[g*FANIN_W +: FANIN_W];
        // each bit passes when it is either not selected or matches its polarity
        assign ok = (~tm | fanin_i) & (~cm | ~fanin_i);
        assign pt_o[g] = lit_and(|(tm | cm), &ok);
    end

endmodule

// File: rtl/mc_steer.sv
module mc_steer
    import mc_pkg::*;
#(
    parameter int NUM_PT = 5
) (
    input  logic [NUM_PT-1:0]         pt_i,
    input  logic [NUM_PT*STEER_W-1:0] steer_i,
    input  logic                      gclk_i,
    input  logic                      grst_i,
    input  logic                      goe_i,
    output logic                      sum_o,
    output ctl_s                      ctl_o
);

    logic clk_or, rst_or, set_or, oe_or;
    logic clk_any, rst_any, oe_any;

    always_comb begin
        sum_o   = 1'b0;
        clk_or  = 1'b0;
        rst_or  = 1'b0;
        set_or  = 1'b0;
        oe_or   = 1'b0;
        clk_any = 1'b0;
        rst_any = 1'b0;
        oe_any  = 1'b0;
        for (int i = 0; i < NUM_PT; i++) begin
            case (steer_i[i*STEER_W +: STEER_W])
                STEER_SUM:  sum_o = sum_o | pt_i[i];
                STEER_CLK:  begin clk_or = clk_or | pt_i[i]; clk_any = 1'b1; end
                STEER_ARST: begin rst_or = rst_or | pt_i[i]; rst_any = 1'b1; end
                STEER_ASET: set_or = set_or | pt_i[i];
                STEER_OE:   begin oe_or = oe_or | pt_i[i]; oe_any = 1'b1; end
                default:    ; // unconnected term
            endcase
        end
        ctl_o.sclk = clk_any ? clk_or : gclk_i;
        ctl_o.arst = rst_any ? rst_or : grst_i;
        ctl_o.aset = set_or;
        ctl_o.oe   = oe_any ? oe_or : goe_i;
    end

endmodule

// File: rtl/mc_regcell.sv
module mc_regcell
    import mc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    input  ctl_s ctl_i,
    input  logic bypass_i,
    output logic q_state_o,
    output logic val_o
);

    logic prev_clk;
    logic q_r;
    logic rising;
    logic q_eff;

    assign rising = ctl_i.sclk & ~prev_clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_clk <= 1'b0;
            q_r      <= 1'b0;
        end else begin
            prev_clk <= ctl_i.sclk;
            if (ctl_i.arst)
                q_r <= 1'b0;
            else if (ctl_i.aset)
                q_r <= 1'b1;
            else if (rising)
                q_r <= d_i;
        end
    end

    // clear and preset reach the output without waiting for an edge
    always_comb begin
        if (ctl_i.arst)
            q_eff = 1'b0;
        else if (ctl_i.aset)
            q_eff = 1'b1;
        else
            q_eff = q_r;
    end

    assign val_o     = bypass_i ? d_i : q_eff;
    assign q_state_o = q_r;

endmodule

// File: rtl/pt_macrocell.sv
module pt_macrocell
    import mc_pkg::*;
#(
    parameter int NUM_PT  = 5,
    parameter int FANIN_W = 40
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [FANIN_W-1:0]          fanin_i,
    input  logic [NUM_PT*FANIN_W-1:0]   cfg_true_i,
    input  logic [NUM_PT*FANIN_W-1:0]   cfg_comp_i,
    input  logic [NUM_PT*STEER_W-1:0]   cfg_steer_i,
    input  logic                        cfg_bypass_i,
    input  logic                        cfg_invert_i,
    input  logic                        gclk_i,
    input  logic                        grst_i,
    input  logic                        goe_i,
    output logic                        dout_o,
    output logic                        oe_o
);

    logic [NUM_PT-1:0] pt;
    logic              sum;
    logic              d_val;
    logic              q_state;
    ctl_s              ctl;

    mc_pterm_array #(.NUM_PT(NUM_PT), .FANIN_W(FANIN_W)) u_terms (
        .fanin_i (fanin_i),
        .true_i  (cfg_true_i),
        .comp_i  (cfg_comp_i),
        .pt_o    (pt)
    );

    mc_steer #(.NUM_PT(NUM_PT)) u_steer (
        .pt_i    (pt),
        .steer_i (cfg_steer_i),
        .gclk_i  (gclk_i),
        .grst_i  (grst_i),
        .goe_i   (goe_i),
        .sum_o   (sum),
        .ctl_o   (ctl)
    );

    assign d_val = sum ^ cfg_invert_i;

    mc_regcell u_reg (
        .clk       (clk),
        .rst       (rst),
        .d_i       (d_val),
        .ctl_i     (ctl),
        .bypass_i  (cfg_bypass_i),
        .q_state_o (q_state),
        .val_o     (dout_o)
    );

    assign oe_o = ctl.oe;

endmodule

// File: rtl/mc_checker.sv
module mc_checker
    import mc_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic bypass,
    input logic d,
    input ctl_s ctl,
    input logic q,
    input logic dout
);

    logic prev_sclk;
    always_ff @(posedge clk) begin
        if (rst) prev_sclk <= 1'b0;
        else     prev_sclk <= ctl.sclk;
    end

    // R6
    clear_forces_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!bypass && ctl.arst) |-> (dout == 1'b0));

    // R7
    preset_forces_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!bypass && ctl.aset && !ctl.arst) |-> (dout == 1'b1));

    // R5
    capture_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.sclk && !prev_sclk && !ctl.arst && !ctl.aset) |=> (q == $past(d)));

    // R5
    hold_without_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!(ctl.sclk && !prev_sclk) && !ctl.arst && !ctl.aset) |=> $stable(q));

    // R4
    bypass_passes_logic_chk: assert property (@(posedge clk) disable iff (rst)
        bypass |-> (dout == d));

endmodule

bind pt_macrocell mc_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .bypass (cfg_bypass_i),
    .d      (d_val),
    .ctl    (ctl),
    .q      (q_state),
    .dout   (dout_o)
);

// File: tb/test_pt_macrocell.sv
`timescale 1ns/1ps
module test_pt_macrocell;

    localparam int NP = 5;
    localparam int FW = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [FW-1:0]     fanin = '0;
    logic [NP*FW-1:0]  tmask = '0;
    logic [NP*FW-1:0]  cmask = '0;
    logic [NP*3-1:0]   steer = '1;
    logic              bypass = 1'b0;
    logic              inv = 1'b0;
    logic              gclk = 1'b0;
    logic              grst = 1'b0;
    logic              goe = 1'b0;
    logic              dout, oe;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pt_macrocell #(.NUM_PT(NP), .FANIN_W(FW)) i_pt_macrocell (
        .clk(clk), .rst(rst), .fanin_i(fanin),
        .cfg_true_i(tmask), .cfg_comp_i(cmask), .cfg_steer_i(steer),
        .cfg_bypass_i(bypass), .cfg_invert_i(inv),
        .gclk_i(gclk), .grst_i(grst), .goe_i(goe),
        .dout_o(dout), .oe_o(oe)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic set_pt(input int i, input logic [FW-1:0] t, input logic [FW-1:0] c,
                          input logic [2:0] s);
        tmask[i*FW +: FW] = t;
        cmask[i*FW +: FW] = c;
        steer[i*3 +: 3]   = s;
    endtask

    task automatic clear_cfg();
        tmask = '0;
        cmask = '0;
        steer = '1;
    endtask

    function automatic logic exp_term(input logic [FW-1:0] t, input logic [FW-1:0] c,
                                      input logic [FW-1:0] x);
        return ((t | c) != 0) && ((x & t) == t) && ((~x & c) == c);
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [4:0] e;
        logic       expv;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: register cleared by reset
        check("R9 reset state", dout, 1'b0);
        check("R8 oe falls back to goe=0", oe, 1'b0);

        // R1: exhaustive masks and inputs for one term, bypassed
        bypass = 1'b1;
        for (int t = 0; t < 16; t++)
            for (int c = 0; c < 16; c++)
                for (int x = 0; x < 16; x++) begin
                    clear_cfg();
                    set_pt(0, FW'(t), FW'(c), 3'd0);
                    fanin = FW'(x);
                    #1;
                    check("R1 term literals", dout, exp_term(FW'(t), FW'(c), FW'(x)));
                end

        // R2 R3 R4: steering subsets, unconnected codes 5..7, polarity
        for (int p = 0; p < 32; p++)
            for (int iv = 0; iv < 2; iv++)
                for (int x = 0; x < 16; x++) begin
                    clear_cfg();
                    set_pt(0, 4'b0001, 4'b0000, p[0] ? 3'd0 : 3'd5);
                    set_pt(1, 4'b0010, 4'b0000, p[1] ? 3'd0 : 3'd6);
                    set_pt(2, 4'b0000, 4'b0100, p[2] ? 3'd0 : 3'd7);
                    set_pt(3, 4'b1001, 4'b0000, p[3] ? 3'd0 : 3'd5);
                    set_pt(4, 4'b0000, 4'b1010, p[4] ? 3'd0 : 3'd6);
                    inv   = iv[0];
                    fanin = FW'(x);
                    #1;
                    e[0] = fanin[0];
                    e[1] = fanin[1];
                    e[2] = ~fanin[2];
                    e[3] = fanin[0] & fanin[3];
                    e[4] = ~fanin[1] & ~fanin[3];
                    expv = (|(e & p[4:0])) ^ iv[0];
                    check("R3 R2 R4 sum of steered terms", dout, expv);
                end
        inv = 1'b0;

        // R8: output enable fallback and term-driven enable
        clear_cfg();
        for (int g = 0; g < 2; g++) begin
            goe = g[0];
            #1;
            check("R8 oe follows goe without oe term", oe, g[0]);
        end
        set_pt(4, 4'b0000, 4'b1010, 3'd4);
        for (int g = 0; g < 2; g++)
            for (int x = 0; x < 16; x++) begin
                goe   = g[0];
                fanin = FW'(x);
                #1;
                check("R8 oe from term, goe ignored", oe, ~fanin[1] & ~fanin[3]);
            end
        goe = 1'b0;

        // R5: registered path with global clock
        @(negedge clk);
        clear_cfg();
        set_pt(0, 4'b0001, 4'b0000, 3'd0);
        bypass = 1'b0;
        gclk   = 1'b0;
        fanin  = 4'b0001;
        @(negedge clk);
        gclk = 1'b1;
        @(negedge clk);
        check("R5 capture on gclk rise", dout, 1'b1);
        fanin = 4'b0000;
        @(negedge clk);
        @(negedge clk);
        check("R5 hold while gclk stays high", dout, 1'b1);
        gclk = 1'b0;
        @(negedge clk);
        check("R5 hold on gclk fall", dout, 1'b1);
        gclk = 1'b1;
        @(negedge clk);
        check("R5 capture 0 on next rise", dout, 1'b0);
        for (int v = 0; v < 16; v++) begin
            gclk     = 1'b0;
            fanin[0] = v[0] ^ v[2];
            @(negedge clk);
            gclk = 1'b1;
            @(negedge clk);
            check("R5 sweep capture", dout, v[0] ^ v[2]);
        end
        gclk  = 1'b0;
        fanin = 4'b0000;

        // R5: term-driven clock, global clock ignored
        set_pt(1, 4'b0010, 4'b0000, 3'd1);
        @(negedge clk);
        @(negedge clk);
        fanin = 4'b0001;
        gclk  = 1'b1;
        @(negedge clk);
        gclk = 1'b0;
        @(negedge clk);
        gclk = 1'b1;
        @(negedge clk);
        check("R5 gclk ignored with clock term", dout, 1'b0);
        gclk  = 1'b0;
        fanin = 4'b0011;
        @(negedge clk);
        check("R5 capture on term clock rise", dout, 1'b1);
        fanin = 4'b0010;
        @(negedge clk);
        check("R5 term clock held high no capture", dout, 1'b1);
        fanin = 4'b0000;
        @(negedge clk);
        fanin = 4'b0010;
        @(negedge clk);
        check("R5 capture 0 on term clock rise", dout, 1'b0);

        // R6: term-driven clear, immediate and persistent
        fanin = 4'b0001;
        @(negedge clk);
        fanin = 4'b0011;
        @(negedge clk);
        check("R5 reload 1 before clear test", dout, 1'b1);
        set_pt(2, 4'b0100, 4'b0000, 3'd2);
        fanin = 4'b0111;
        #1;
        check("R6 clear acts without edge", dout, 1'b0);
        @(negedge clk);
        fanin = 4'b0011;
        #1;
        check("R6 register cleared after edge", dout, 1'b0);

        // R6: global clear fallback
        fanin = 4'b0001;
        @(negedge clk);
        fanin = 4'b0011;
        @(negedge clk);
        check("R5 reload 1 before global clear", dout, 1'b1);
        set_pt(2, 4'b0100, 4'b0000, 3'd7);
        grst = 1'b1;
        #1;
        check("R6 grst used without clear term", dout, 1'b0);
        @(negedge clk);
        grst = 1'b0;
        #1;
        check("R6 register cleared by grst", dout, 1'b0);

        // R7: preset and priority
        set_pt(2, 4'b0100, 4'b0000, 3'd2);
        set_pt(3, 4'b1000, 4'b0000, 3'd3);
        fanin = 4'b1000;
        #1;
        check("R7 preset forces 1", dout, 1'b1);
        fanin = 4'b1100;
        #1;
        check("R7 clear wins over preset", dout, 1'b0);
        @(negedge clk);
        fanin = 4'b0000;
        #1;
        check("R7 register cleared under both", dout, 1'b0);
        fanin = 4'b1000;
        @(negedge clk);
        fanin = 4'b0000;
        #1;
        check("R7 register set by preset", dout, 1'b1);

        // R9: synchronous reset clears the register
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R9 reset clears register", dout, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule